// File: doc/BRIEF.md
# System Control Coprocessor Register Bank

This block is a small bank of eight 32-bit registers that the core reaches only through coprocessor register-transfer operations. A move-to-coprocessor port writes a register and a move-from-coprocessor port reads one. In both cases the register index is decoded from the instruction word. A separate debug port reads and writes the same registers by a plain index.

Register 0 always reads back a fixed identification value. Register 1 is the control register, and four of its bits drive core configuration outputs: program address width, data address width, late abort timing and byte order. At reset those four bits are loaded from strap inputs.

Whenever a write to the control register actually changes one of the four configuration bits, the block raises a one-cycle mode-change pulse. The core uses this pulse to re-evaluate its configuration.

Top module: `sccp_top`

## Requirements
- R1: While reset is held and after it is released, the control register reads `{24'b0, strap_big_endian, strap_late_abort, strap_data_wide, strap_prog_wide, 4'b0}`. The configuration outputs equal the straps. Registers 2..7 read 0. `mode_change`, `mcr_done`, `mrc_done` and `dbg_ack` are 0.
- R2: The register index of a transfer instruction is instruction bits 18:16. Bit 19 and all other instruction bits are ignored, so an index field of 9 selects register 1.
- R3: A read of register 0 through either the transfer read port or the debug port returns 32'h41440110, whatever was written to it.
- R4: Registers 1..7 keep all 32 written bits, including the control register bits 3:0 and 31:8 that have no function, and read them back unchanged.
- R5: After a write to register 1 the configuration outputs take its bits: `cfg_prog_wide` takes bit 4, `cfg_data_wide` bit 5, `cfg_late_abort` bit 6 and `cfg_big_endian` bit 7. They are valid from the cycle after the write and otherwise hold.
- R6: `mode_change` is high for exactly the cycle after a write to register 1 from either port in which bits 7:4 differ from their previous value. It stays low for writes that leave bits 7:4 unchanged and for writes to other registers.
- R7: `mcr_done` and `mrc_done` are high in the cycle after the matching valid input and low otherwise. `mrc_data` holds the read result in that cycle.
- R8: A debug access with `dbg_idx` of 8 or more is ignored: no register changes and `dbg_ack` stays low. An in-range access raises `dbg_ack` the next cycle, and for a read it returns the register on `dbg_rdata`.
- R9: When a transfer write and a debug write occur in the same cycle, the transfer write takes effect and the debug write is dropped.
- R10: A read in the same cycle as a write to the same register returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_prog_wide | input | 1 | Reset value of the program width bit |
| strap_data_wide | input | 1 | Reset value of the data width bit |
| strap_late_abort | input | 1 | Reset value of the late abort bit |
| strap_big_endian | input | 1 | Reset value of the byte order bit |
| mcr_valid | input | 1 | Transfer write request |
| mcr_instr | input | 32 | Instruction word of the write |
| mcr_data | input | 32 | Value to write |
| mcr_done | output | 1 | Write acknowledge |
| mrc_valid | input | 1 | Transfer read request |
| mrc_instr | input | 32 | Instruction word of the read |
| mrc_data | output | 32 | Read result |
| mrc_done | output | 1 | Read acknowledge |
| dbg_valid | input | 1 | Debug access request |
| dbg_we | input | 1 | Debug write (1) or read (0) |
| dbg_idx | input | 4 | Debug register index |
| dbg_wdata | input | 32 | Debug write value |
| dbg_rdata | output | 32 | Debug read result |
| dbg_ack | output | 1 | Debug acknowledge for in-range index |
| cfg_prog_wide | output | 1 | Program address width select |
| cfg_data_wide | output | 1 | Data address width select |
| cfg_late_abort | output | 1 | Late abort timing select |
| cfg_big_endian | output | 1 | Byte order select |
| mode_change | output | 1 | One-cycle pulse on a configuration change |

## Verification
The control register is written with several patterns. One flips configuration bits, which must pulse. One changes only the unused low and high bits, which must store but not pulse. One rewrites the identical value, and one goes through the debug port. These patterns separate a change detector from a write detector. Instruction words with bit 19 and unrelated bits set show whether the index is masked correctly. Debug indices above 7, colliding writes from both ports, and a read that overlaps a write to the same register pin down the priority and the read-before-write ordering.

// File: rtl/sccp_pkg.sv
package sccp_pkg;
  // Configuration bits in control-register order (LSB = program width)
  typedef struct packed {
    logic big_endian;
    logic late_abort;
    logic data_wide;
    logic prog_wide;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  // True when a new configuration differs from the current one in any bit
  function automatic logic cfg_differs(cfg_t cur, cfg_t nxt);
    return (cur ^ nxt) != '0;
  endfunction

  // Select the fixed ID for index 0, the stored word otherwise
  function automatic logic [31:0] read_mux(logic is_zero, logic [31:0] id,
                                           logic [31:0] stored);
    return is_zero ? id : stored;
  endfunction
endpackage

// File: rtl/sccp_write_arb.sv
module sccp_write_arb #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              mcr_valid,
  input  logic [IDX_W-1:0]  mcr_idx,
  input  logic [DATA_W-1:0] mcr_data,
  input  logic              dbg_wr,
  input  logic [IDX_W-1:0]  dbg_idx,
  input  logic [DATA_W-1:0] dbg_data,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_data
);
  // Transfer port has priority over debug port
  always_comb begin
    wr_en   = mcr_valid | dbg_wr;
    wr_idx  = mcr_valid ? mcr_idx  : dbg_idx;
    wr_data = mcr_valid ? mcr_data : dbg_data;
  end
endmodule

// File: rtl/sccp_regfile.sv
module sccp_regfile #(
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 3,
  parameter int CTRL_IDX = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] ctrl_rst_word,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [IDX_W-1:0]  rd_idx_b,
  output logic [DATA_W-1:0] rd_data_b,
  output logic [DATA_W-1:0] ctrl_word
);
  localparam int N_REGS = 1 << IDX_W;

  logic [DATA_W-1:0] mem [N_REGS];

  for (genvar i = 0; i < N_REGS; i++) begin : g_reg
    if (i == CTRL_IDX) begin : g_ctrl
      always_ff @(posedge clk) begin
        if (!rst_n)                           mem[i] <= ctrl_rst_word;
        else if (wr_en && wr_idx == IDX_W'(i)) mem[i] <= wr_data;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rst_n)                           mem[i] <= '0;
        else if (wr_en && wr_idx == IDX_W'(i)) mem[i] <= wr_data;
      end
    end
  end

  assign rd_data_a = mem[rd_idx_a];
  assign rd_data_b = mem[rd_idx_b];
  assign ctrl_word = mem[CTRL_IDX];
endmodule

// File: rtl/sccp_mode_watch.sv
module sccp_mode_watch
  import sccp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_wr_evt,
  input  cfg_t cfg_cur,
  input  cfg_t cfg_new,
  output logic mode_change
);
  always_ff @(posedge clk) begin
    if (!rst_n) mode_change <= 1'b0;
    else        mode_change <= ctrl_wr_evt && cfg_differs(cfg_cur, cfg_new);
  end
endmodule

// File: rtl/sccp_top.sv
module sccp_top
  import sccp_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          IDX_W     = 3,
  parameter int          DBG_IDX_W = 4,
  parameter int          IDX_LSB   = 16,
  parameter int          CTRL_IDX  = 1,
  parameter int          CFG_LSB   = 4,
  parameter logic [31:0] ID_VALUE  = 32'h4144_0110
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 strap_prog_wide,
  input  logic                 strap_data_wide,
  input  logic                 strap_late_abort,
  input  logic                 strap_big_endian,
  input  logic                 mcr_valid,
  input  logic [31:0]          mcr_instr,
  input  logic [DATA_W-1:0]    mcr_data,
  output logic                 mcr_done,
  input  logic                 mrc_valid,
  input  logic [31:0]          mrc_instr,
  output logic [DATA_W-1:0]    mrc_data,
  output logic                 mrc_done,
  input  logic                 dbg_valid,
  input  logic                 dbg_we,
  input  logic [DBG_IDX_W-1:0] dbg_idx,
  input  logic [DATA_W-1:0]    dbg_wdata,
  output logic [DATA_W-1:0]    dbg_rdata,
  output logic                 dbg_ack,
  output logic                 cfg_prog_wide,
  output logic                 cfg_data_wide,
  output logic                 cfg_late_abort,
  output logic                 cfg_big_endian,
  output logic                 mode_change
);
  localparam int N_REGS = 1 << IDX_W;

  // Index decode (upper bits of the 4-bit field are masked off)
  logic [IDX_W-1:0] mcr_idx, mrc_idx, dbg_loc;
  logic             dbg_in_range, dbg_accept;
  assign mcr_idx      = mcr_instr[IDX_LSB +: IDX_W];
  assign mrc_idx      = mrc_instr[IDX_LSB +: IDX_W];
  assign dbg_loc      = dbg_idx[IDX_W-1:0];
  assign dbg_in_range = (dbg_idx >> IDX_W) == '0;
  assign dbg_accept   = dbg_valid && dbg_in_range;

  // Reset word for the control register from the straps
  cfg_t              strap_cfg;
  logic [DATA_W-1:0] ctrl_rst_word;
  assign strap_cfg     = '{big_endian: strap_big_endian, late_abort: strap_late_abort,
                           data_wide: strap_data_wide, prog_wide: strap_prog_wide};
  assign ctrl_rst_word = DATA_W'(strap_cfg) << CFG_LSB;

  // Write arbitration
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] wr_data;

  sccp_write_arb #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_arb (
    .mcr_valid (mcr_valid),
    .mcr_idx   (mcr_idx),
    .mcr_data  (mcr_data),
    .dbg_wr    (dbg_accept && dbg_we),
    .dbg_idx   (dbg_loc),
    .dbg_data  (dbg_wdata),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data)
  );

  // Storage
  logic [DATA_W-1:0] rd_a, rd_b, ctrl_word;

  sccp_regfile #(.DATA_W(DATA_W), .IDX_W(IDX_W), .CTRL_IDX(CTRL_IDX)) u_rf (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctrl_rst_word (ctrl_rst_word),
    .wr_en         (wr_en),
    .wr_idx        (wr_idx),
    .wr_data       (wr_data),
    .rd_idx_a      (mrc_idx),
    .rd_data_a     (rd_a),
    .rd_idx_b      (dbg_loc),
    .rd_data_b     (rd_b),
    .ctrl_word     (ctrl_word)
  );

  // Configuration and change detection (named for the checker)
  cfg_t cfg_bus, cfg_next;
  logic ctrl_wr_evt;
  assign cfg_bus     = cfg_t'(ctrl_word[CFG_LSB +: CFG_W]);
  assign cfg_next    = cfg_t'(wr_data[CFG_LSB +: CFG_W]);
  assign ctrl_wr_evt = wr_en && (wr_idx == IDX_W'(CTRL_IDX));

  sccp_mode_watch u_watch (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_wr_evt (ctrl_wr_evt),
    .cfg_cur     (cfg_bus),
    .cfg_new     (cfg_next),
    .mode_change (mode_change)
  );

  assign cfg_prog_wide  = cfg_bus.prog_wide;
  assign cfg_data_wide  = cfg_bus.data_wide;
  assign cfg_late_abort = cfg_bus.late_abort;
  assign cfg_big_endian = cfg_bus.big_endian;

  // Registered acknowledges and read data
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mcr_done  <= 1'b0;
      mrc_done  <= 1'b0;
      dbg_ack   <= 1'b0;
      mrc_data  <= '0;
      dbg_rdata <= '0;
    end else begin
      mcr_done <= mcr_valid;
      mrc_done <= mrc_valid;
      dbg_ack  <= dbg_accept;
      if (mrc_valid)
        mrc_data <= read_mux(mrc_idx == '0, ID_VALUE, rd_a);
      if (dbg_accept && !dbg_we)
        dbg_rdata <= read_mux(dbg_loc == '0, ID_VALUE, rd_b);
    end
  end

  initial begin
    if (N_REGS <= CTRL_IDX) $error("CTRL_IDX out of range");
  end
endmodule

// File: rtl/sccp_checker.sv
module sccp_checker #(
  parameter int          DATA_W    = 32,
  parameter int          IDX_W     = 3,
  parameter int          DBG_IDX_W = 4,
  parameter int          IDX_LSB   = 16,
  parameter logic [31:0] ID_VALUE  = 32'h4144_0110
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 mcr_valid,
  input logic                 mcr_done,
  input logic                 mrc_valid,
  input logic                 mrc_done,
  input logic [31:0]          mrc_instr,
  input logic [DATA_W-1:0]    mrc_data,
  input logic                 dbg_valid,
  input logic [DBG_IDX_W-1:0] dbg_idx,
  input logic                 dbg_ack,
  input logic                 ctrl_wr_evt,
  input logic [3:0]           cfg_bus,
  input logic                 mode_change
);
  logic mrc_zero_req, dbg_oob_req;
  assign mrc_zero_req = mrc_valid && (mrc_instr[IDX_LSB +: IDX_W] == '0);
  assign dbg_oob_req  = dbg_valid && ((dbg_idx >> IDX_W) != '0);

  a_r7_mcr_done: assert property (@(posedge clk) disable iff (!rst_n)
    mcr_valid |=> mcr_done);
  a_r7_mrc_done: assert property (@(posedge clk) disable iff (!rst_n)
    mrc_valid |=> mrc_done);
  a_r3_id_read: assert property (@(posedge clk) disable iff (!rst_n)
    mrc_zero_req |=> (mrc_data == ID_VALUE));
  a_r6_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    mode_change |-> ($past(ctrl_wr_evt) && (cfg_bus != $past(cfg_bus))));
  a_r5_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ctrl_wr_evt) |-> $stable(cfg_bus));
  a_r8_dbg_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_oob_req |=> !dbg_ack);
endmodule

bind sccp_top sccp_checker #(
  .DATA_W(DATA_W), .IDX_W(IDX_W), .DBG_IDX_W(DBG_IDX_W),
  .IDX_LSB(IDX_LSB), .ID_VALUE(ID_VALUE)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mcr_valid   (mcr_valid),
  .mcr_done    (mcr_done),
  .mrc_valid   (mrc_valid),
  .mrc_done    (mrc_done),
  .mrc_instr   (mrc_instr),
  .mrc_data    (mrc_data),
  .dbg_valid   (dbg_valid),
  .dbg_idx     (dbg_idx),
  .dbg_ack     (dbg_ack),
  .ctrl_wr_evt (ctrl_wr_evt),
  .cfg_bus     (cfg_bus),
  .mode_change (mode_change)
);

// File: tb/sccp_top_tb.sv
module sccp_top_tb;
  localparam logic [31:0] ID = 32'h4144_0110;

  logic clk = 0, rst_n = 0;
  logic s_prog = 0, s_data = 1, s_late = 0, s_big = 1;
  logic mcr_valid = 0, mrc_valid = 0, dbg_valid = 0, dbg_we = 0;
  logic [31:0] mcr_instr = 0, mcr_data = 0, mrc_instr = 0, dbg_wdata = 0;
  logic [3:0]  dbg_idx = 0;
  logic [31:0] mrc_data, dbg_rdata;
  logic mcr_done, mrc_done, dbg_ack, mode_change;
  logic c_prog, c_data, c_late, c_big;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sccp_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .strap_prog_wide(s_prog), .strap_data_wide(s_data),
    .strap_late_abort(s_late), .strap_big_endian(s_big),
    .mcr_valid(mcr_valid), .mcr_instr(mcr_instr), .mcr_data(mcr_data), .mcr_done(mcr_done),
    .mrc_valid(mrc_valid), .mrc_instr(mrc_instr), .mrc_data(mrc_data), .mrc_done(mrc_done),
    .dbg_valid(dbg_valid), .dbg_we(dbg_we), .dbg_idx(dbg_idx), .dbg_wdata(dbg_wdata),
    .dbg_rdata(dbg_rdata), .dbg_ack(dbg_ack),
    .cfg_prog_wide(c_prog), .cfg_data_wide(c_data), .cfg_late_abort(c_late),
    .cfg_big_endian(c_big), .mode_change(mode_change)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] instr_for(input logic [3:0] field);
    return 32'hEE00_0F10 | (32'(field) << 16);
  endfunction

  // Transfer write; returns done and mode pulse seen in the following cycle
  task automatic mcr_wr(input logic [3:0] field, input logic [31:0] d,
                        output logic dn, output logic mc);
    @(negedge clk);
    mcr_valid = 1; mcr_instr = instr_for(field); mcr_data = d;
    @(posedge clk); #1;
    dn = mcr_done; mc = mode_change;
    @(negedge clk);
    mcr_valid = 0;
  endtask

  task automatic mrc_rd(input logic [3:0] field, output logic [31:0] d);
    @(negedge clk);
    mrc_valid = 1; mrc_instr = instr_for(field);
    @(posedge clk); #1;
    d = mrc_data;
    check(mrc_done === 1'b1, "R7 mrc_done", 32'(mrc_done), 1);
    @(negedge clk);
    mrc_valid = 0;
    @(posedge clk); #1;
    check(mrc_done === 1'b0, "R7 mrc_done drop", 32'(mrc_done), 0);
  endtask

  task automatic dbg_op(input logic we, input logic [3:0] idx, input logic [31:0] wd,
                        output logic ack, output logic [31:0] rd, output logic mc);
    @(negedge clk);
    dbg_valid = 1; dbg_we = we; dbg_idx = idx; dbg_wdata = wd;
    @(posedge clk); #1;
    ack = dbg_ack; rd = dbg_rdata; mc = mode_change;
    @(negedge clk);
    dbg_valid = 0; dbg_we = 0;
  endtask

  function automatic logic [3:0] cfg_now();
    return {c_big, c_late, c_data, c_prog};
  endfunction

  task automatic t_reset();
    logic [31:0] r;
    check(cfg_now() == 4'b1010, "R1 cfg from straps", 32'(cfg_now()), 32'hA);
    check(mode_change === 0 && mcr_done === 0 && mrc_done === 0 && dbg_ack === 0,
          "R1 idle outputs", {mode_change, mcr_done, mrc_done, dbg_ack}, 0);
    mrc_rd(4'd1, r); check(r == 32'hA0, "R1 ctrl reset", r, 32'hA0);
    mrc_rd(4'd5, r); check(r == 0, "R1 reg5 reset", r, 0);
  endtask

  task automatic t_id();
    logic dn, mc, ack; logic [31:0] r;
    mcr_wr(4'd0, 32'hDEAD_BEEF, dn, mc);
    check(dn === 1'b1, "R7 mcr_done", 32'(dn), 1);
    mrc_rd(4'd0, r); check(r == ID, "R3 id via transfer", r, ID);
    dbg_op(0, 4'd0, 0, ack, r, mc); check(r == ID && ack, "R3 id via debug", r, ID);
  endtask

  task automatic t_store();
    logic dn, mc; logic [31:0] r;
    for (int i = 2; i < 8; i++) mcr_wr(4'(i), 32'h1357_9BD0 ^ (32'(i) * 32'h0101_1111), dn, mc);
    for (int i = 2; i < 8; i++) begin
      mrc_rd(4'(i), r);
      check(r == (32'h1357_9BD0 ^ (32'(i) * 32'h0101_1111)), "R4 readback", r,
            32'h1357_9BD0 ^ (32'(i) * 32'h0101_1111));
    end
  endtask

  task automatic t_index();
    logic dn, mc; logic [31:0] r;
    mrc_rd(4'd11, r);            // bit 19 set, low field 3
    check(r == (32'h1357_9BD0 ^ 32'h0303_3333), "R2 bit19 masked", r,
          32'h1357_9BD0 ^ 32'h0303_3333);
    mcr_wr(4'd14, 32'h0000_6666, dn, mc); // lands in reg 6
    mrc_rd(4'd6, r); check(r == 32'h6666, "R2 write alias", r, 32'h6666);
  endtask

  task automatic t_cfg();
    logic dn, mc; logic [31:0] r;
    mcr_wr(4'd1, 32'h0000_0050, dn, mc);
    check(mc === 1'b1, "R6 pulse on change", 32'(mc), 1);
    check(cfg_now() == 4'b0101, "R5 cfg bits", 32'(cfg_now()), 32'h5);
    @(posedge clk); #1;
    check(mode_change === 1'b0, "R6 single cycle", 32'(mode_change), 0);
    mcr_wr(4'd1, 32'hFFFF_FF5F, dn, mc);
    check(mc === 1'b0, "R6 no pulse unused bits", 32'(mc), 0);
    mrc_rd(4'd1, r); check(r == 32'hFFFF_FF5F, "R4 ctrl full word", r, 32'hFFFF_FF5F);
    mcr_wr(4'd1, 32'hFFFF_FF5F, dn, mc);
    check(mc === 1'b0, "R6 no pulse same value", 32'(mc), 0);
    mcr_wr(4'd2, 32'h0000_00F0, dn, mc);
    check(mc === 1'b0 && cfg_now() == 4'b0101, "R6 other reg", {mc, 27'd0, cfg_now()}, 32'h5);
  endtask

  task automatic t_dbg();
    logic ack, mc; logic [31:0] r;
    dbg_op(1, 4'd9, 32'h0000_0000, ack, r, mc);
    check(ack === 1'b0 && mc === 1'b0, "R8 oob write no ack", 32'(ack), 0);
    mrc_rd(4'd1, r); check(r == 32'hFFFF_FF5F, "R8 oob write ignored", r, 32'hFFFF_FF5F);
    dbg_op(0, 4'd12, 0, ack, r, mc);
    check(ack === 1'b0, "R8 oob read no ack", 32'(ack), 0);
    dbg_op(1, 4'd1, 32'h0000_0080, ack, r, mc);
    check(ack === 1'b1 && mc === 1'b1, "R6 debug write pulse", {ack, mc}, 3);
    check(cfg_now() == 4'b1000, "R5 cfg via debug", 32'(cfg_now()), 32'h8);
    dbg_op(0, 4'd5, 0, ack, r, mc);
    check(r == (32'h1357_9BD0 ^ 32'h0505_5555), "R8 debug read", r,
          32'h1357_9BD0 ^ 32'h0505_5555);
  endtask

  task automatic t_collide();
    logic [31:0] r;
    @(negedge clk);
    mcr_valid = 1; mcr_instr = instr_for(4'd4); mcr_data = 32'hAAAA_0001;
    dbg_valid = 1; dbg_we = 1; dbg_idx = 4'd4; dbg_wdata = 32'hBBBB_0002;
    @(negedge clk);
    mcr_valid = 0; dbg_valid = 0; dbg_we = 0;
    mrc_rd(4'd4, r); check(r == 32'hAAAA_0001, "R9 transfer wins", r, 32'hAAAA_0001);
  endtask

  task automatic t_rdwr();
    logic [31:0] r;
    @(negedge clk);
    mcr_valid = 1; mcr_instr = instr_for(4'd7); mcr_data = 32'h7777_0000;
    mrc_valid = 1; mrc_instr = instr_for(4'd7);
    @(posedge clk); #1;
    r = mrc_data;
    check(r == (32'h1357_9BD0 ^ 32'h0707_7777), "R10 old value", r,
          32'h1357_9BD0 ^ 32'h0707_7777);
    @(negedge clk);
    mcr_valid = 0; mrc_valid = 0;
    mrc_rd(4'd7, r); check(r == 32'h7777_0000, "R10 new value", r, 32'h7777_0000);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    t_reset();
    t_id();
    t_store();
    t_index();
    t_cfg();
    t_dbg();
    t_collide();
    t_rdwr();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule